// File: doc/BRIEF.md
# Boot Control Register for Paged Flash and FPGA Configuration

This block sits on a processor's external-memory bus and turns writes into a control region into three side effects: it selects which half of a paged flash device is visible, it drives the reconfigure (program) pin of an FPGA, and it clocks a serial configuration bitstream out one bit per write. The command is carried in the write address, not in the data. The word offset picks the function, and address bit 0 carries the value for page and program-pin writes.

The flash sits behind two chip-select windows of 2 MB each. The upper-window select drives flash address line 22 and the page bit drives flash address line 21. The two windows therefore form one 4 MB range: with page 0 the lower window reaches section 1 and the upper window reaches section 3, and with page 1 they reach sections 2 and 4. Boot software loads the FPGA by writing the configuration address once per bitstream bit. Each write produces one clock pulse, with write-data bit 0 presented on the data pin. The bus is assumed to be already synchronous to `clk`. A write is held by the master until `bus_ready` is high on a clock edge.

Top module: `boot_ctl`

## Requirements
- R1: When `rst_n` is sampled low on a clock edge, the block selects page 0 after that edge, releases the program pin (`fpga_prog_n` = 1), drives `cfg_clk` low and `cfg_dout` low, and raises `bus_ready`.
- R2: A write taken to page offset 0x00000 (word offset 0, that is address 0x00000 or 0x00001) sets the page bit to address bit 0 from the next cycle. The value on `bus_wdata` has no effect on the page.
- R3: `flash_a_hi[0]` equals the page bit and `flash_a_hi[1]` equals `bus_cs_flash_hi`, so line 22 picks the window and line 21 picks the page section.
- R4: A write taken to program offset 0x02000 with address bit 0 = 0 drives `fpga_prog_n` low from the next cycle. The same write with bit 0 = 1 drives it high.
- R5: A write taken to configuration offset 0x08000 (bit 0 ignored) raises `cfg_clk` on the next cycle. `cfg_clk` then stays high for HIGH_CYC cycles, stays low for LOW_CYC cycles, and produces exactly one pulse per write.
- R6: `cfg_dout` takes `bus_wdata[0]` of the configuration write in the cycle the pulse starts, and it does not change until the next configuration write is taken.
- R7: `bus_ready` is low from the cycle the pulse starts until its low phase ends. A write presented while `bus_ready` is low has no effect until a clock edge on which `bus_ready` is high.
- R8: While `bus_cs_ctrl` is high, `bus_rdata` returns the page bit in bit 0 and 1 in bit 1 if the program pin is asserted, with all other bits 0. While `bus_cs_ctrl` is low, `bus_rdata` is 0.
- R9: A write to any other word offset in the control region changes neither the page, the program pin nor the configuration outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_cs_ctrl | input | 1 | Control region selected |
| bus_cs_flash_hi | input | 1 | Upper 2 MB flash window selected |
| bus_addr | input | ADDR_W (20) | Bus word address; bit 0 carries the command value |
| bus_wdata | input | DATA_W (32) | Write data; only bit 0 is used, for configuration writes |
| bus_we | input | 1 | Write strobe, held until taken |
| bus_ready | output | 1 | High when a write can be taken this cycle |
| bus_rdata | output | DATA_W (32) | Readback of page and program state |
| flash_a_hi | output | 2 | Flash address lines 22 and 21 |
| fpga_prog_n | output | 1 | FPGA program pin, active low |
| cfg_clk | output | 1 | Serial configuration clock |
| cfg_dout | output | 1 | Serial configuration data |

## Verification
The hardest situation to reach is a write that arrives while a configuration pulse is still in progress, especially a page or program write that waits in the low phase and must land on exactly the first edge where `bus_ready` returns. The stimulus issues configuration writes back to back and follows each one at once with a page or program write. It also pulls reset in the middle of a pulse. A behavioural model that counts the remaining high and low cycles is compared with every output on every clock.

// File: rtl/boot_ctl_pkg.sv
// Shared types for the boot control register.
// Assumes: nothing beyond IEEE 1800-2017 enums.
package boot_ctl_pkg;
    typedef enum logic [1:0] {
        CMD_NONE = 2'd0,
        CMD_PAGE = 2'd1,
        CMD_PROG = 2'd2,
        CMD_CCLK = 2'd3
    } cmd_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_HIGH = 2'd1,
        PH_LOW  = 2'd2
    } phase_e;
endpackage

// File: rtl/boot_ctl_decode.sv
// Address decoder: turns a write that is taken into a single command.
// Assumes the bus is synchronous to clk and that a write counts only when
// ready is high. Address bit 0 is the command value and is passed out as val.
module boot_ctl_decode
    import boot_ctl_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter logic [ADDR_W-2:0] PAGE_OFS = 'h00000,
    parameter logic [ADDR_W-2:0] PROG_OFS = 'h01000,
    parameter logic [ADDR_W-2:0] CCLK_OFS = 'h04000
) (
    input  logic              cs,
    input  logic              we,
    input  logic              ready,
    input  logic [ADDR_W-1:0] addr,
    output cmd_e              cmd,
    output logic              val
);
    logic take;

    // A write is taken when it is selected, strobed and not stalled.
    assign take = cs && we && ready;
    assign val  = addr[0];

    // Match the word offset against the three fixed command offsets.
    always_comb begin
        cmd = CMD_NONE;
        if (take) begin
            if (addr[ADDR_W-1:1] == PAGE_OFS)      cmd = CMD_PAGE;
            else if (addr[ADDR_W-1:1] == PROG_OFS) cmd = CMD_PROG;
            else if (addr[ADDR_W-1:1] == CCLK_OFS) cmd = CMD_CCLK;
        end
    end
endmodule

// File: rtl/boot_ctl_regs.sv
// Holds the flash page bit and the program-pin state.
// Assumes commands arrive as one-cycle codes from the decoder.
module boot_ctl_regs
    import boot_ctl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  cmd_e cmd,
    input  logic val,
    output logic page,
    output logic prog_on
);
    // Update the page and program state on their own commands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            page    <= 1'b0;
            prog_on <= 1'b0;
        end else begin
            if (cmd == CMD_PAGE) page <= val;
            if (cmd == CMD_PROG) prog_on <= !val;
        end
    end

    assert_page_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_PAGE) |=> (page == $past(val)));
    assert_prog_follows_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_PROG) |=> (prog_on == !$past(val)));
    assert_page_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd != CMD_PAGE) |=> $stable(page));
endmodule

// File: rtl/boot_ctl_cclk.sv
// Configuration pulse generator: one start makes one clock pulse,
// HIGH_CYC cycles high and then LOW_CYC cycles low, with the data bit
// latched at the start. busy covers both phases.
// Assumes start is issued only while busy is low.
module boot_ctl_cclk
    import boot_ctl_pkg::*;
#(
    parameter int HIGH_CYC = 2,
    parameter int LOW_CYC  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic din,
    output logic cclk,
    output logic cdata,
    output logic busy
);
    localparam int MAXC = (HIGH_CYC > LOW_CYC) ? HIGH_CYC : LOW_CYC;
    localparam int CW   = $clog2(MAXC) + 1;

    phase_e        phase;
    logic [CW-1:0] cnt;

    // Walk the idle, high and low phases and count each one down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            cnt   <= '0;
            cdata <= 1'b0;
        end else begin
            case (phase)
                PH_IDLE: if (start) begin
                    phase <= PH_HIGH;
                    cnt   <= CW'(HIGH_CYC - 1);
                    cdata <= din;
                end
                PH_HIGH: if (cnt == '0) begin
                    phase <= PH_LOW;
                    cnt   <= CW'(LOW_CYC - 1);
                end else begin
                    cnt <= cnt - 1'b1;
                end
                PH_LOW: if (cnt == '0) phase <= PH_IDLE;
                        else cnt <= cnt - 1'b1;
                default: phase <= PH_IDLE;
            endcase
        end
    end

    assign cclk = (phase == PH_HIGH);
    assign busy = (phase != PH_IDLE);

    assert_start_raises_R5: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> cclk);
    assert_low_phase_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cclk) |-> busy);
    assert_data_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> $stable(cdata));
    assert_no_start_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !start);
endmodule

// File: rtl/boot_ctl.sv
// Boot control register top: decodes bus writes into page select,
// program-pin control and one-pulse-per-write configuration clocking,
// and returns page and program state on reads.
// Assumes a synchronous bus whose master holds a write until bus_ready.
module boot_ctl
    import boot_ctl_pkg::*;
#(
    parameter int ADDR_W   = 20,
    parameter int DATA_W   = 32,
    parameter int HIGH_CYC = 2,
    parameter int LOW_CYC  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_cs_ctrl,
    input  logic              bus_cs_flash_hi,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_we,
    output logic              bus_ready,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [1:0]        flash_a_hi,
    output logic              fpga_prog_n,
    output logic              cfg_clk,
    output logic              cfg_dout
);
    cmd_e cmd;
    logic val, page, prog_on, busy;

    boot_ctl_decode #(.ADDR_W(ADDR_W)) u_decode (
        .cs(bus_cs_ctrl), .we(bus_we), .ready(bus_ready),
        .addr(bus_addr), .cmd(cmd), .val(val)
    );

    boot_ctl_regs u_regs (
        .clk(clk), .rst_n(rst_n), .cmd(cmd), .val(val),
        .page(page), .prog_on(prog_on)
    );

    boot_ctl_cclk #(.HIGH_CYC(HIGH_CYC), .LOW_CYC(LOW_CYC)) u_cclk (
        .clk(clk), .rst_n(rst_n), .start(cmd == CMD_CCLK), .din(bus_wdata[0]),
        .cclk(cfg_clk), .cdata(cfg_dout), .busy(busy)
    );

    // Stall all control writes while a pulse is in flight.
    assign bus_ready   = !busy;
    assign flash_a_hi  = {bus_cs_flash_hi, page};
    assign fpga_prog_n = !prog_on;

    // Readback of state in the two low bits.
    always_comb begin
        bus_rdata = '0;
        if (bus_cs_ctrl) bus_rdata[1:0] = {prog_on, page};
    end

    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (flash_a_hi[0] == 1'b0 && fpga_prog_n && !cfg_clk && bus_ready));
    assert_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_cs_ctrl && !bus_ready) |=> ($stable(fpga_prog_n) && $stable(cfg_dout)));
    assert_unmapped_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_cs_ctrl && bus_ready && cmd == CMD_NONE)
        |=> ($stable(fpga_prog_n) && $stable(flash_a_hi[0]) && !cfg_clk));
endmodule

// File: tb/boot_ctl_bench.sv
// Bench: behavioural model of page, program pin and pulse timing,
// compared with every output at each falling edge.
module boot_ctl_bench;
    localparam int HI = 3;
    localparam int LO = 2;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        cs_ctrl = 0, cs_fhi = 0, we = 0;
    logic [19:0] addr = '0;
    logic [31:0] wdata = '0;
    logic        ready, prog_n, cclk, cdout;
    logic [31:0] rdata;
    logic [1:0]  fhi;

    int checks = 0, errors = 0;
    bit cmp_en = 0;

    // model state
    int m_page = 0, m_prog = 0, m_hi = 0, m_lo = 0, m_dat = 0;

    always #10 clk = ~clk;

    boot_ctl #(.HIGH_CYC(HI), .LOW_CYC(LO)) u_boot_ctl (
        .clk(clk), .rst_n(rst_n), .bus_cs_ctrl(cs_ctrl), .bus_cs_flash_hi(cs_fhi),
        .bus_addr(addr), .bus_wdata(wdata), .bus_we(we), .bus_ready(ready),
        .bus_rdata(rdata), .flash_a_hi(fhi), .fpga_prog_n(prog_n),
        .cfg_clk(cclk), .cfg_dout(cdout)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference model, advanced on each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_page = 0; m_prog = 0; m_hi = 0; m_lo = 0; m_dat = 0;
        end else begin
            automatic bit was_busy = (m_hi > 0) || (m_lo > 0);
            if (m_hi > 0) begin
                m_hi--;
                if (m_hi == 0) m_lo = LO;
            end else if (m_lo > 0) begin
                m_lo--;
            end
            if (we && cs_ctrl && !was_busy) begin
                case (addr >> 1)
                    20'h00000: m_page = addr[0];
                    20'h01000: m_prog = !addr[0];
                    20'h04000: begin m_hi = HI; m_dat = wdata[0]; end
                    default: ;
                endcase
            end
        end
    end

    // Compare all outputs with the model away from the rising edge.
    always @(negedge clk) begin
        if (cmp_en) begin
            chk("R2 page", 32'(fhi[0]), 32'(m_page));
            chk("R3 flash window", 32'(fhi[1]), 32'(cs_fhi));
            chk("R4 prog pin", 32'(prog_n), 32'(!m_prog));
            chk("R5 cfg clock", 32'(cclk), 32'(m_hi > 0));
            chk("R6 cfg data", 32'(cdout), 32'(m_dat));
            chk("R7 ready", 32'(ready), 32'(!((m_hi > 0) || (m_lo > 0))));
            chk("R8 readback", rdata, cs_ctrl ? 32'((m_prog << 1) | m_page) : 32'h0);
        end
    end

    // Present a write and hold it until an edge where ready is high.
    task automatic bus_write(input logic [19:0] a, input logic [31:0] d);
        bit done = 0;
        @(posedge clk); #2;
        cs_ctrl = 1; addr = a; wdata = d; we = 1;
        while (!done) begin
            @(negedge clk);
            done = ready;
            @(posedge clk); #2;
        end
        we = 0; cs_ctrl = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk("R1 page after reset", 32'(fhi[0]), 32'h0);
        chk("R1 prog after reset", 32'(prog_n), 32'h1);
        chk("R1 cclk after reset", 32'(cclk), 32'h0);
        chk("R1 ready after reset", 32'(ready), 32'h1);
        cmp_en = 1;
        @(posedge clk); #2; rst_n = 1;

        // R2: page select, data ignored
        bus_write(20'h00001, 32'h0);
        idle(1);
        bus_write(20'h00000, 32'hFFFF_FFFF);
        idle(1);
        @(negedge clk); chk("R2 data ignored", 32'(fhi[0]), 32'h0);
        bus_write(20'h00001, 32'hFFFF_FFFF);
        // R3: window line follows the upper select
        @(posedge clk); #2; cs_fhi = 1;
        idle(2);
        @(negedge clk); chk("R3 upper window page1", 32'(fhi), 32'h3);
        @(posedge clk); #2; cs_fhi = 0;

        // R4: program pin
        bus_write(20'h02000, 32'h1);
        idle(2);
        @(negedge clk); chk("R4 prog asserted", 32'(prog_n), 32'h0);
        // R8: readback while selected
        @(posedge clk); #2; cs_ctrl = 1;
        @(negedge clk); chk("R8 read state", rdata, 32'h3);
        @(posedge clk); #2; cs_ctrl = 0;
        bus_write(20'h02001, 32'h0);

        // R5 R6: a run of configuration bits with upper data noise
        bus_write(20'h08000, 32'hFFFF_FFFF);
        bus_write(20'h08001, 32'hFFFF_FFFE);
        bus_write(20'h08000, 32'h0000_0001);
        bus_write(20'h08000, 32'h0000_0001);
        // R7: page and program writes stalled behind a pulse
        bus_write(20'h08000, 32'h0);
        bus_write(20'h00000, 32'h0);
        bus_write(20'h08000, 32'h1);
        bus_write(20'h02000, 32'h0);
        idle(HI + LO + 2);
        @(negedge clk); chk("R7 stalled prog landed", 32'(prog_n), 32'h0);

        // R9: unmapped offset leaves everything alone
        bus_write(20'h10001, 32'hFFFF_FFFF);
        bus_write(20'h02003, 32'h0);
        idle(2);
        @(negedge clk);
        chk("R9 prog unchanged", 32'(prog_n), 32'h0);
        chk("R9 page unchanged", 32'(fhi[0]), 32'h0);
        chk("R9 no pulse", 32'(cclk), 32'h0);

        // R1: reset in the middle of a pulse
        bus_write(20'h00001, 32'h0);
        bus_write(20'h08000, 32'h1);
        @(posedge clk); #2; rst_n = 0;
        @(posedge clk); #2;
        @(negedge clk);
        chk("R1 mid-pulse reset cclk", 32'(cclk), 32'h0);
        chk("R1 mid-pulse reset ready", 32'(ready), 32'h1);
        chk("R1 mid-pulse reset page", 32'(fhi[0]), 32'h0);
        @(posedge clk); #2; rst_n = 1;
        bus_write(20'h08000, 32'h1);
        idle(HI + LO + 2);

        cmp_en = 0;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule